// File: doc/BRIEF.md
# Signed and Unsigned Integer Divide/Remainder Unit

This block computes the quotient and remainder of two integer operands of the same width. A mode input selects whether both operands are two's-complement signed or plain unsigned. An iterative unsigned divider does the work. It retires `LOG2_RADIX` quotient bits per clock, so a pass takes `ceil(WIDTH/LOG2_RADIX)` cycles. Before the pass starts, the operands are reduced to magnitudes. After the pass ends, signs are applied to the results, so the outcome follows the common integer-ISA rules: the quotient truncates toward zero and the remainder takes the sign of the dividend.

A pulse on `start` while the unit is idle captures the operands and the mode. `busy` stays high while the operation runs. `done` pulses for one cycle when `quotient` and `remainder` are valid. Both results then hold until the next completion. Neither corner case raises a fault, and each produces a fixed result:
- Division by zero returns a quotient of all ones and a remainder equal to the dividend.
- The most negative value divided by −1 wraps.

Top module: `divsign_top`

## Requirements
- R1: In unsigned mode (`is_signed`=0) with a non-zero divisor, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor, both as unsigned WIDTH-bit values (at width 4: 15÷4 gives 3 remainder 3).
- R2: In signed mode (`is_signed`=1) with a non-zero divisor, the quotient truncates toward zero. It is negative exactly when the operand signs differ and the magnitude quotient is non-zero (at width 4: −7÷2 gives quotient −3 = 4'hD).
- R3: In signed mode, a non-zero remainder has the sign of the dividend and a magnitude below the divisor's magnitude (at width 4: −7÷2 gives remainder −1 = 4'hF; 7÷−3 gives quotient −2 = 4'hE and remainder 1).
- R4: A zero divisor gives a quotient of all ones and a remainder equal to the dividend, in both modes.
- R5: In signed mode, the most negative value divided by −1 gives a quotient equal to the most negative value and a remainder of 0 (at width 4: 4'h8 ÷ 4'hF gives 4'h8 remainder 0).
- R6: After `start` is accepted at a clock edge, `busy` is high from that edge on. `done` rises exactly ceil(WIDTH/LOG2_RADIX)+1 edges later and stays high for one cycle, with `busy` low in that cycle.
- R7: While `busy` is high, `start` and any change on the operand or mode inputs have no effect: the running operation completes with the values captured at its start, and no second operation follows.
- R8: `quotient` and `remainder` change only in a cycle where `done` is high and otherwise hold their values.
- R9: While `rst_n` is low at a clock edge, `busy`, `done`, `quotient` and `remainder` become 0.
- R10: Results are identical for every LOG2_RADIX from 1 to 4 over all operand pairs and both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| is_signed | input | 1 | 1: operands are two's complement; 0: unsigned |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | WIDTH | Quotient, truncated to WIDTH |
| remainder | output | WIDTH | Remainder, truncated to WIDTH |

## Verification
The bound checker watches every cycle for several properties:
- The handshake timing: the one-cycle `done` pulse, `busy` and `done` never high together, and the latency counted from the accepted start.
- Result hold between completions.
- The reset values.
- The divide-by-zero result, the wrapping overflow result and the rule that a signed remainder takes the dividend's sign, each judged against operands the checker latched at start.

The exact quotient and remainder values for ordinary operands can only be shown by the bench, which runs every 4-bit operand pair in both modes against a model on four radix variants. The bench also covers the case where `start` is raised during a busy operation.

// File: rtl/divsign_pkg.sv
// Shared types for the signed/unsigned divide unit.
package divsign_pkg;
    // Top-level sequencing state.
    typedef enum logic {
        DS_IDLE = 1'b0,
        DS_RUN  = 1'b1
    } ds_state_e;
endpackage

// File: rtl/divsign_mag.sv
// Operand magnitude extraction.
// Produces the unsigned magnitude of one operand and its sign flag.
// Assumes a negated most-negative value is read as an unsigned WIDTH-bit
// number, so it needs no extra bit.
module divsign_mag #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             sgn_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    // Sign is meaningful only in signed mode.
    assign neg_o = sgn_i & val_i[WIDTH-1];
    // Two's-complement negate when negative.
    assign mag_o = neg_o ? (~val_i + WIDTH'(1)) : val_i;
endmodule

// File: rtl/divsign_core.sv
// Iterative unsigned restoring divider, radix 2**LOG2_RADIX.
// Each active cycle picks the largest quotient digit whose shifted multiple
// of the divisor fits in the partial remainder. A zero divisor yields an
// all-ones quotient and leaves the dividend untouched.
// Assumes load_i is raised only when the core is not running.
module divsign_core #(
    parameter int WIDTH      = 32,
    parameter int LOG2_RADIX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] dvd_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic             fin_o,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);
    localparam int RADIX = 1 << LOG2_RADIX;
    localparam int STEPS = (WIDTH + LOG2_RADIX - 1) / LOG2_RADIX;
    localparam int TOPSH = (STEPS - 1) * LOG2_RADIX;
    localparam int SW    = $clog2(TOPSH + 2);
    localparam int PW    = WIDTH + LOG2_RADIX;

    logic [WIDTH-1:0]      rem_q, quo_q, dvs_q;
    logic [SW-1:0]         sh_q;
    logic                  run_q, fin_q;
    logic [WIDTH-1:0]      hi;
    logic [PW-1:0]         prod [RADIX];
    logic [RADIX-1:0]      fits;
    logic [LOG2_RADIX-1:0] digit;
    logic [WIDTH-1:0]      new_hi, low_mask, rem_nx, quo_nx;

    // Partial remainder aligned to the current digit position.
    assign hi = rem_q >> sh_q;

    // Candidate multiples of the divisor, one per digit value.
    for (genvar i = 0; i < RADIX; i++) begin : g_cand
        assign prod[i] = PW'(i) * PW'(dvs_q);
        assign fits[i] = (PW'(hi) >= prod[i]);
    end

    // Highest fitting candidate selects the digit.
    always_comb begin
        digit = '0;
        for (int k = 0; k < RADIX; k++) begin
            if (fits[k]) digit = LOG2_RADIX'(k);
        end
    end

    // Next remainder and quotient.
    always_comb begin
        new_hi   = hi - WIDTH'(prod[digit]);
        low_mask = ~({WIDTH{1'b1}} << sh_q);
        rem_nx   = (new_hi << sh_q) | (rem_q & low_mask);
        quo_nx   = quo_q | WIDTH'(PW'(digit) << sh_q);
    end

    // Load, step and finish sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            sh_q  <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                rem_q <= dvd_i;
                quo_q <= '0;
                dvs_q <= dvs_i;
                sh_q  <= SW'(TOPSH);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                if (sh_q == '0) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end else begin
                    sh_q <= sh_q - SW'(LOG2_RADIX);
                end
            end
        end
    end

    assign fin_o = fin_q;
    assign quo_o = quo_q;
    assign rem_o = rem_q;
endmodule

// File: rtl/divsign_fix.sv
// Result sign correction.
// Negates the magnitude quotient and remainder as flagged, wrapping to WIDTH.
// Assumes the flags were settled at operation start.
module divsign_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] uq_i,
    input  logic [WIDTH-1:0] ur_i,
    input  logic             neg_q_i,
    input  logic             neg_r_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] r_o
);
    // Conditional two's-complement negation of each result.
    assign q_o = neg_q_i ? (~uq_i + WIDTH'(1)) : uq_i;
    assign r_o = neg_r_i ? (~ur_i + WIDTH'(1)) : ur_i;
endmodule

// File: rtl/divsign_top.sv
// Signed/unsigned integer divide and remainder unit.
// Takes magnitudes at start, runs the unsigned core, then applies signs:
// the quotient is negated when the signs differ and the divisor is non-zero,
// and the remainder is negated when the dividend is negative.
// Assumes start is honoured only while idle.
module divsign_top #(
    parameter int WIDTH      = 32,
    parameter int LOG2_RADIX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    import divsign_pkg::*;

    ds_state_e        state_q;
    logic             neg_q_q, neg_r_q, done_q, accept;
    logic [WIDTH-1:0] quo_q, rem_q;
    logic [WIDTH-1:0] dvd_mag, dvs_mag, core_q, core_r, fix_q, fix_r;
    logic             dvd_neg, dvs_neg, core_fin;

    assign accept = start && (state_q == DS_IDLE);

    divsign_mag #(.WIDTH(WIDTH)) u_mag_dvd (
        .val_i(dividend), .sgn_i(is_signed), .mag_o(dvd_mag), .neg_o(dvd_neg)
    );
    divsign_mag #(.WIDTH(WIDTH)) u_mag_dvs (
        .val_i(divisor), .sgn_i(is_signed), .mag_o(dvs_mag), .neg_o(dvs_neg)
    );

    divsign_core #(.WIDTH(WIDTH), .LOG2_RADIX(LOG2_RADIX)) u_core (
        .clk(clk), .rst_n(rst_n), .load_i(accept),
        .dvd_i(dvd_mag), .dvs_i(dvs_mag),
        .fin_o(core_fin), .quo_o(core_q), .rem_o(core_r)
    );

    divsign_fix #(.WIDTH(WIDTH)) u_fix (
        .uq_i(core_q), .ur_i(core_r), .neg_q_i(neg_q_q), .neg_r_i(neg_r_q),
        .q_o(fix_q), .r_o(fix_r)
    );

    // Sequencing, sign-flag capture and result registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
            done_q  <= 1'b0;
            quo_q   <= '0;
            rem_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                DS_IDLE: if (start) begin
                    state_q <= DS_RUN;
                    neg_q_q <= (dvd_neg ^ dvs_neg) && (divisor != '0);
                    neg_r_q <= dvd_neg;
                end
                DS_RUN: if (core_fin) begin
                    state_q <= DS_IDLE;
                    quo_q   <= fix_q;
                    rem_q   <= fix_r;
                    done_q  <= 1'b1;
                end
                default: state_q <= DS_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == DS_RUN);
    assign done      = done_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;
endmodule

// File: rtl/divsign_chk.sv
// Protocol and corner-case checker for divsign_top.
// Latches the operands of each accepted start and checks the handshake,
// the hold behaviour and the fixed-result cases at completion.
module divsign_chk #(
    parameter int WIDTH      = 32,
    parameter int LOG2_RADIX = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             is_signed,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder
);
    localparam int STEPS = (WIDTH + LOG2_RADIX - 1) / LOG2_RADIX;
    localparam int CW    = $clog2(STEPS + 4);
    localparam logic [WIDTH-1:0] MOSTNEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] c_dvd, c_dvs;
    logic             c_sgn;
    logic [CW-1:0]    lat;

    // Operand capture and latency count per operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_dvd <= '0;
            c_dvs <= '0;
            c_sgn <= 1'b0;
            lat   <= '0;
        end else if (start && !busy) begin
            c_dvd <= dividend;
            c_dvs <= divisor;
            c_sgn <= is_signed;
            lat   <= '0;
        end else if (busy && lat != {CW{1'b1}}) begin
            lat <= lat + CW'(1);
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == CW'(STEPS + 1)));
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_div_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_dvs == '0) |-> (quotient == {WIDTH{1'b1}} && remainder == c_dvd));
    assert_overflow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_sgn && c_dvd == MOSTNEG && c_dvs == {WIDTH{1'b1}})
        |-> (quotient == MOSTNEG && remainder == '0));
    assert_rem_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_sgn && remainder != '0) |-> (remainder[WIDTH-1] == c_dvd[WIDTH-1]));
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || ($stable(quotient) && $stable(remainder))));
    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && quotient == '0 && remainder == '0));
endmodule

bind divsign_top divsign_chk #(.WIDTH(WIDTH), .LOG2_RADIX(LOG2_RADIX)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
);

// File: tb/divsign_top_tb.sv
`timescale 1ns/1ps
// Directed bench: four instances at width 4, radix exponents 1 to 4.
module divsign_top_tb;
    localparam int W  = 4;
    localparam int NV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sgn_in = 1'b0;
    logic [W-1:0] dvd = '0, dvs = '0;
    logic [NV-1:0] busy_v, done_v;
    logic [NV-1:0][W-1:0] q_v, r_v;
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < NV; g++) begin : g_dut
        divsign_top #(.WIDTH(W), .LOG2_RADIX(g + 1)) u_dut (
            .clk(clk), .rst_n(rst_n), .start(start), .is_signed(sgn_in),
            .dividend(dvd), .divisor(dvs), .busy(busy_v[g]), .done(done_v[g]),
            .quotient(q_v[g]), .remainder(r_v[g])
        );
    end

    // Expected done latency in edges after the start edge (R6).
    function automatic int lat_of(input int g);
        return (W + g) / (g + 1) + 1;
    endfunction

    // Reference: truncating division, dividend-signed remainder, fixed corners.
    function automatic logic [2*W-1:0] model(input logic [W-1:0] a, b, input logic s);
        int sa, sb, q, r;
        if (b == '0) return {{W{1'b1}}, a};
        sa = s ? int'($signed(a)) : int'(a);
        sb = s ? int'($signed(b)) : int'(b);
        q = sa / sb;
        r = sa % sb;
        return {q[W-1:0], r[W-1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation on all instances; optional disturbance while busy (R7).
    task automatic run_op(input logic [W-1:0] a, b, input logic s,
                          input logic [W-1:0] eq, er, input string tag, input bit disturb);
        logic [NV-1:0] got = '0;
        @(negedge clk);
        dvd = a; dvs = b; sgn_in = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy_v == '1, "R6 busy after start", int'(busy_v), 'hF);
        for (int k = 1; k <= 8 && got != '1; k++) begin
            if (disturb && k == 1) begin
                start = 1'b1; dvd = ~a; dvs = 4'd1; sgn_in = ~s;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            for (int g = 0; g < NV; g++) begin
                if (!got[g]) begin
                    if (done_v[g]) begin
                        got[g] = 1'b1;
                        check(k == lat_of(g), "R6 latency", k, lat_of(g));
                        check(!busy_v[g], "R6 busy low at done", int'(busy_v[g]), 0);
                        check(q_v[g] == eq, {tag, " quotient"}, int'(q_v[g]), int'(eq));
                        check(r_v[g] == er, {tag, " remainder"}, int'(r_v[g]), int'(er));
                    end else begin
                        check(busy_v[g], "R6 busy while running", int'(busy_v[g]), 1);
                    end
                end
            end
        end
        start = 1'b0;
        check(got == '1, "R6 all done", int'(got), 'hF);
    endtask

    // Outputs hold and no operation starts while start stays low (R7, R8).
    task automatic check_quiet(input int n, input string req);
        logic [NV-1:0][W-1:0] hq = q_v, hr = r_v;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dvd = W'(i + 3); dvs = W'(i); sgn_in = i[0];
            check(done_v == '0 && busy_v == '0, req, int'({busy_v, done_v}), 0);
            check(q_v == hq && r_v == hr, {req, " hold"}, int'(q_v[0]), int'(hq[0]));
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy_v == '0 && done_v == '0, "R9 flags", int'({busy_v, done_v}), 0);
        check(q_v == '0 && r_v == '0, "R9 results", int'(q_v[0]), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_directed;
        run_op(4'd15, 4'd4, 1'b0, 4'd3, 4'd3, "R1 15/4", 0);
        run_op(4'h9, 4'h2, 1'b1, 4'hD, 4'hF, "R2 R3 -7/2", 0);
        run_op(4'h7, 4'hD, 1'b1, 4'hE, 4'h1, "R2 R3 7/-3", 0);
        run_op(4'h8, 4'hF, 1'b1, 4'h8, 4'h0, "R5 -8/-1", 0);
        run_op(4'h5, 4'h0, 1'b1, 4'hF, 4'h5, "R4 signed 5/0", 0);
        run_op(4'hB, 4'h0, 1'b1, 4'hF, 4'hB, "R4 signed -5/0", 0);
        run_op(4'h9, 4'h0, 1'b0, 4'hF, 4'h9, "R4 unsigned 9/0", 0);
    endtask

    task automatic t_busy_ignore;
        run_op(4'd13, 4'd3, 1'b0, 4'd4, 4'd1, "R7 start while busy", 1);
        check_quiet(8, "R7 R8 idle after op");
    endtask

    task automatic t_exhaustive;
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [2*W-1:0] e = model(W'(a), W'(b), s[0]);
                    string tag = (b == 0) ? "R4 R10" :
                                 (s == 0) ? "R1 R10" :
                                 (a == 8 && b == 15) ? "R5 R10" : "R2 R3 R10";
                    run_op(W'(a), W'(b), s[0], e[2*W-1:W], e[W-1:0], tag, 0);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_directed();
        t_busy_ignore();
        t_exhaustive();
        check_quiet(4, "R8 final hold");
        t_reset();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule